// File: doc/BRIEF.md
# Breakpoint Value Register Bank

This block holds the 64-bit comparison values for a set of hardware breakpoints and makes them reachable from an external debug port through a small memory-mapped window. A request carries an offset, a write flag and write data. One cycle later the bank returns a response with three parts: whether it claimed the offset, whether the access faulted, and the read data.

Every access is screened against the debug lock and power status. Any blocking condition turns the access into a fault. A software lock makes the bank read-only. Slots in the window beyond the number of breakpoints that are built read as zero. When a blocking condition is present, such a slot either faults or reads as zero, as set by a parameter.

Each slot also carries a 4-bit breakpoint type that comes from outside the bank. In address-matching types, the bank shapes what it presents. The two lowest bits read as zero. The bits above the top implemented address bit can be tied to a copy of that bit. The shaped values are driven in parallel to a separate match unit.

Top module: `bkpt_value_bank`

## Requirements
- R1: The bank claims an offset only if it lies in [BASE_OFF, BASE_OFF + 64*16) and is a multiple of 16 from BASE_OFF (default BASE_OFF = 0x400); the slot is (offset - BASE_OFF)/16. For an unclaimed offset the response shows claim 0, error 0 and data 0, and no slot changes.
- R2: Every request yields exactly one response, with rsp_vld_o high in the cycle after the request. A write that is allowed is visible on a later read and on bkpt_val_o from the cycle after the request.
- R3: An access is blocked when dbl_lock_i is 1, core_on_i is 0, os_lock_i is 1 or ext_ok_i is 0. For an implemented slot, a blocked access returns error 1 with data 0, and a blocked write leaves the slot unchanged.
- R4: When no blocking condition holds and sw_lock_i is 1, a read returns the slot's value without error, and a write returns no error but leaves the slot unchanged.
- R5: A slot at or above NUM_BKPT that is accessed without a blocking condition reads as zero, returns no error and ignores writes.
- R6: A slot at or above NUM_BKPT that is accessed while blocked returns error equal to UNIMPL_ERR (default 1), with data 0.
- R7: A type is address-matching when type bit 3 is 0 and type bit 1 is 0. In that case bits [1:0] of the presented value read as 0.
- R8: In address-matching types with SX_HARDWIRE = 1 (default), bits [63:VA_MSB+1] read as copies of bit VA_MSB (default VA_MSB = 48).
- R9: In all other types the presented value is the stored 64-bit value unchanged.
- R10: bkpt_val_o[64*n +: 64] always shows the same shaped value that a read of slot n returns, and it follows changes to that slot's type without any write.
- R11: While reset is asserted and after it is released, rsp_vld_o is 0 until a request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | 64 | Write data |
| dbl_lock_i | input | 1 | Double lock active (blocks) |
| core_on_i | input | 1 | Core powered (0 blocks) |
| os_lock_i | input | 1 | OS lock active (blocks) |
| ext_ok_i | input | 1 | External debug permitted (0 blocks) |
| sw_lock_i | input | 1 | Software lock: read-only when set |
| bkpt_type_i | input | 4*NUM_BKPT | Breakpoint type per slot, slot n at [4n+3:4n] |
| rsp_vld_o | output | 1 | Response valid |
| rsp_claim_o | output | 1 | Offset claimed by the bank |
| rsp_err_o | output | 1 | Access faulted |
| rsp_rdata_o | output | 64 | Read data (0 for writes and faults) |
| bkpt_val_o | output | 64*NUM_BKPT | Shaped values for the match unit |

## Verification
The bench aims at the edges of the window and the stride. These are the first and last slot, an offset one stride below the window, the first offset above it, and offsets aligned to 4 or 8 bytes but not 16. A decoder that claimed such an offset would corrupt slot 0 or return non-zero data. Each of the four blocking conditions is applied on its own, to catch a gate that ORs in only some of them. Writes under the software lock and under a blocking condition are read back afterwards, to expose a gate that faults correctly but still lets the write through. Values with the top address bit set and with it clear show whether the sign copy and the low-bit clearing look at the type and at the right bit. A type flip with no write shows whether the match-unit outputs shape the value live or latch it at write time.

// File: rtl/bkpt_value_pkg.sv
package bkpt_value_pkg;

  localparam int VAL_W      = 64;
  localparam int TYPE_W     = 4;
  localparam int WIN_SLOTS  = 64;
  localparam int STRIDE_LG2 = 4;
  localparam int IDX_W      = $clog2(WIN_SLOTS);

  typedef logic [VAL_W-1:0]  val_t;
  typedef logic [TYPE_W-1:0] btype_t;
  typedef logic [IDX_W-1:0]  idx_t;

  typedef struct packed {
    logic err;
    logic rd_ok;
    logic wr_en;
  } perm_t;

  // address-matching types: bit 3 and bit 1 both clear
  function automatic logic is_addr_mode(btype_t t);
    return (t[3] == 1'b0) && (t[1] == 1'b0);
  endfunction

  function automatic val_t fmt_view(val_t raw, btype_t t, logic sx_hw, logic [IDX_W-1:0] msb);
    val_t v;
    v = raw;
    if (is_addr_mode(t)) begin
      v[1:0] = 2'b00;
      if (sx_hw) begin
        for (int b = 0; b < VAL_W; b++) begin
          if (b > int'(msb)) v[b] = raw[msb];
        end
      end
    end
    return v;
  endfunction

endpackage

// File: rtl/bkpt_value_decode.sv
module bkpt_value_decode
  import bkpt_value_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BASE_OFF = 'h400,
  parameter int NUM_BKPT = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output idx_t              idx_o,
  output logic              impl_o
);

  localparam int WIN_BYTES = WIN_SLOTS << STRIDE_LG2;

  logic [ADDR_W-1:0] rel;
  logic              in_win;
  logic              aligned;

  always_comb begin
    rel     = addr_i - ADDR_W'(BASE_OFF);
    in_win  = (addr_i >= ADDR_W'(BASE_OFF)) && (rel < ADDR_W'(WIN_BYTES));
    aligned = (rel[STRIDE_LG2-1:0] == '0);
    hit_o   = in_win && aligned;
    idx_o   = rel[STRIDE_LG2 +: IDX_W];
    impl_o  = (int'(idx_o) < NUM_BKPT);
  end

endmodule

// File: rtl/bkpt_value_gate.sv
module bkpt_value_gate
  import bkpt_value_pkg::*;
#(
  parameter int UNIMPL_ERR = 1
) (
  input  logic  req_i,
  input  logic  we_i,
  input  logic  hit_i,
  input  logic  impl_i,
  input  logic  dbl_lock_i,
  input  logic  core_on_i,
  input  logic  os_lock_i,
  input  logic  ext_ok_i,
  input  logic  sw_lock_i,
  output logic  blocked_o,
  output perm_t perm_o
);

  localparam logic UNIMPL_FAULT = (UNIMPL_ERR != 0);

  logic live;

  always_comb begin
    blocked_o    = dbl_lock_i | ~core_on_i | os_lock_i | ~ext_ok_i;
    live         = req_i & hit_i;
    perm_o.err   = live & blocked_o & (impl_i | UNIMPL_FAULT);
    perm_o.rd_ok = live & impl_i & ~blocked_o;
    perm_o.wr_en = live & impl_i & ~blocked_o & we_i & ~sw_lock_i;
  end

endmodule

// File: rtl/bkpt_value_store.sv
module bkpt_value_store
  import bkpt_value_pkg::*;
#(
  parameter int NUM_BKPT    = 16,
  parameter int VA_MSB      = 48,
  parameter int SX_HARDWIRE = 1
) (
  input  logic                      clk,
  input  logic                      wr_en_i,
  input  idx_t                      idx_i,
  input  val_t                      wdata_i,
  input  logic [NUM_BKPT*TYPE_W-1:0] type_i,
  output val_t                      rd_view_o,
  output logic [NUM_BKPT*VAL_W-1:0] view_o
);

  localparam logic       SX_ON  = (SX_HARDWIRE != 0);
  localparam logic [IDX_W-1:0] MSB_SEL = IDX_W'(VA_MSB);

  val_t                raw_q [NUM_BKPT];
  val_t                raw_d [NUM_BKPT];
  val_t                view  [NUM_BKPT];
  logic [NUM_BKPT-1:0] wr_sel;

  for (genvar g = 0; g < NUM_BKPT; g++) begin : g_slot
    always_comb begin
      wr_sel[g] = wr_en_i && (idx_i == idx_t'(g));
      raw_d[g]  = wdata_i;
      view[g]   = fmt_view(raw_q[g], type_i[g*TYPE_W +: TYPE_W], SX_ON, MSB_SEL);
    end

    // contents have no defined reset value
    always_ff @(posedge clk) begin
      if (wr_sel[g]) raw_q[g] <= raw_d[g];
    end

    assign view_o[g*VAL_W +: VAL_W] = view[g];
  end

  always_comb begin
    rd_view_o = '0;
    for (int k = 0; k < NUM_BKPT; k++) begin
      if (idx_i == idx_t'(k)) rd_view_o = view[k];
    end
  end

endmodule

// File: rtl/bkpt_value_bank.sv
module bkpt_value_bank
  import bkpt_value_pkg::*;
#(
  parameter int NUM_BKPT    = 16,
  parameter int ADDR_W      = 12,
  parameter int BASE_OFF    = 'h400,
  parameter int VA_MSB      = 48,
  parameter int SX_HARDWIRE = 1,
  parameter int UNIMPL_ERR  = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [63:0]                wdata_i,
  input  logic                       dbl_lock_i,
  input  logic                       core_on_i,
  input  logic                       os_lock_i,
  input  logic                       ext_ok_i,
  input  logic                       sw_lock_i,
  input  logic [NUM_BKPT*4-1:0]      bkpt_type_i,
  output logic                       rsp_vld_o,
  output logic                       rsp_claim_o,
  output logic                       rsp_err_o,
  output logic [63:0]                rsp_rdata_o,
  output logic [NUM_BKPT*64-1:0]     bkpt_val_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  logic  dec_hit;
  logic  dec_impl;
  idx_t  dec_idx;
  logic  blocked;
  perm_t perm;
  val_t  rd_view;

  bkpt_value_decode #(
    .ADDR_W  (ADDR_W),
    .BASE_OFF(BASE_OFF),
    .NUM_BKPT(NUM_BKPT)
  ) u_decode (
    .addr_i(addr_i),
    .hit_o (dec_hit),
    .idx_o (dec_idx),
    .impl_o(dec_impl)
  );

  bkpt_value_gate #(
    .UNIMPL_ERR(UNIMPL_ERR)
  ) u_gate (
    .req_i     (req_i),
    .we_i      (we_i),
    .hit_i     (dec_hit),
    .impl_i    (dec_impl),
    .dbl_lock_i(dbl_lock_i),
    .core_on_i (core_on_i),
    .os_lock_i (os_lock_i),
    .ext_ok_i  (ext_ok_i),
    .sw_lock_i (sw_lock_i),
    .blocked_o (blocked),
    .perm_o    (perm)
  );

  bkpt_value_store #(
    .NUM_BKPT   (NUM_BKPT),
    .VA_MSB     (VA_MSB),
    .SX_HARDWIRE(SX_HARDWIRE)
  ) u_store (
    .clk      (clk),
    .wr_en_i  (perm.wr_en),
    .idx_i    (dec_idx),
    .wdata_i  (wdata_i),
    .type_i   (bkpt_type_i),
    .rd_view_o(rd_view),
    .view_o   (bkpt_val_o)
  );

  // response next state
  logic vld_d, claim_d, err_d;
  val_t rdata_d;

  always_comb begin
    vld_d   = req_i;
    claim_d = req_i & dec_hit;
    err_d   = perm.err;
    rdata_d = (perm.rd_ok && !we_i) ? rd_view : '0;
  end

  logic vld_q, claim_q, err_q;
  val_t rdata_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q   <= 1'b0;
      claim_q <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      vld_q   <= vld_d;
      claim_q <= claim_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign rsp_vld_o   = vld_q;
  assign rsp_claim_o = claim_q;
  assign rsp_err_o   = err_q;
  assign rsp_rdata_o = rdata_q;

endmodule

// File: rtl/bkpt_value_bank_chk.sv
module bkpt_value_bank_chk #(
  parameter int NUM_BKPT   = 16,
  parameter int UNIMPL_ERR = 1
) (
  input logic                   clk,
  input logic                   rst_sync_n,
  input logic                   req_i,
  input logic                   we_i,
  input logic                   sw_lock_i,
  input logic                   blocked,
  input logic                   dec_hit,
  input logic                   dec_impl,
  input logic                   rsp_vld_o,
  input logic                   rsp_claim_o,
  input logic                   rsp_err_o,
  input logic [63:0]            rsp_rdata_o,
  input logic [NUM_BKPT*4-1:0]  bkpt_type_i,
  input logic [NUM_BKPT*64-1:0] bkpt_val_o
);

  localparam logic UNIMPL_FAULT = (UNIMPL_ERR != 0);

  p_vld_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_i |=> rsp_vld_o);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_i |=> !rsp_vld_o);

  p_unclaimed_zero_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && !dec_hit) |=> (!rsp_claim_o && !rsp_err_o && rsp_rdata_o == 64'd0));

  p_blocked_fault_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && dec_hit && dec_impl && blocked) |=> (rsp_err_o && rsp_rdata_o == 64'd0));

  p_locked_write_kept_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && we_i && (sw_lock_i || blocked)) |=> (!$stable(bkpt_type_i) || $stable(bkpt_val_o)));

  p_unimpl_open_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && dec_hit && !dec_impl && !blocked) |=> (!rsp_err_o && rsp_rdata_o == 64'd0));

  p_unimpl_blocked_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && dec_hit && !dec_impl && blocked) |=> (rsp_err_o == UNIMPL_FAULT && rsp_rdata_o == 64'd0));

  for (genvar g = 0; g < NUM_BKPT; g++) begin : g_low
    p_low_bits_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (bkpt_type_i[g*4+3] == 1'b0 && bkpt_type_i[g*4+1] == 1'b0) |-> (bkpt_val_o[g*64 +: 2] == 2'b00));
  end

endmodule

bind bkpt_value_bank bkpt_value_bank_chk #(
  .NUM_BKPT  (NUM_BKPT),
  .UNIMPL_ERR(UNIMPL_ERR)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .req_i      (req_i),
  .we_i       (we_i),
  .sw_lock_i  (sw_lock_i),
  .blocked    (blocked),
  .dec_hit    (dec_hit),
  .dec_impl   (dec_impl),
  .rsp_vld_o  (rsp_vld_o),
  .rsp_claim_o(rsp_claim_o),
  .rsp_err_o  (rsp_err_o),
  .rsp_rdata_o(rsp_rdata_o),
  .bkpt_type_i(bkpt_type_i),
  .bkpt_val_o (bkpt_val_o)
);

// File: tb/bkpt_value_bank_bench.sv
module bkpt_value_bank_bench;

  localparam int NB = 16;

  logic              clk;
  logic              rst_n;
  logic              req, we;
  logic [11:0]       addr;
  logic [63:0]       wdata;
  logic              dbl_lock, core_on, os_lock, ext_ok, sw_lock;
  logic [NB*4-1:0]   btype;
  logic              rsp_vld, rsp_claim, rsp_err;
  logic [63:0]       rsp_rdata;
  logic [NB*64-1:0]  bval;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bkpt_value_bank #(.NUM_BKPT(NB)) u_bkpt_value_bank (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .dbl_lock_i(dbl_lock), .core_on_i(core_on), .os_lock_i(os_lock), .ext_ok_i(ext_ok),
    .sw_lock_i(sw_lock), .bkpt_type_i(btype), .rsp_vld_o(rsp_vld), .rsp_claim_o(rsp_claim),
    .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata), .bkpt_val_o(bval)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic        w;
    logic [11:0] a;
    logic [63:0] d;
    logic        claim;
    logic        err;
    logic [63:0] rd;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 12'h400, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0, 64'h0, 4'd2},                  // R2 write slot0
    '{1'b0, 12'h400, 64'h0, 1'b1, 1'b0, 64'hFFFF_4567_89AB_CDEC, 4'd8},                  // R8 R7 sign copy of 1
    '{1'b1, 12'h410, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0, 64'h0, 4'd2},
    '{1'b0, 12'h410, 64'h0, 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, 4'd9},                  // R9 context type raw
    '{1'b1, 12'h430, 64'h8000_0000_0000_0003, 1'b1, 1'b0, 64'h0, 4'd2},
    '{1'b0, 12'h430, 64'h0, 1'b1, 1'b0, 64'h0, 4'd8},                                    // R8 sign copy of 0, R7
    '{1'b1, 12'h420, 64'hFFFF_0000_0000_0007, 1'b1, 1'b0, 64'h0, 4'd2},
    '{1'b0, 12'h420, 64'h0, 1'b1, 1'b0, 64'hFFFF_0000_0000_0007, 4'd9},                  // R9 type 1000
    '{1'b1, 12'h408, 64'h0, 1'b0, 1'b0, 64'h0, 4'd1},                                    // R1 half stride
    '{1'b1, 12'h404, 64'h0, 1'b0, 1'b0, 64'h0, 4'd1},                                    // R1 word offset
    '{1'b0, 12'h400, 64'h0, 1'b1, 1'b0, 64'hFFFF_4567_89AB_CDEC, 4'd1},                  // R1 slot0 untouched
    '{1'b0, 12'h3F0, 64'h0, 1'b0, 1'b0, 64'h0, 4'd1},                                    // R1 below window
    '{1'b0, 12'h800, 64'h0, 1'b0, 1'b0, 64'h0, 4'd1},                                    // R1 above window
    '{1'b1, 12'h540, 64'hDEAD_BEEF_CAFE_F00D, 1'b1, 1'b0, 64'h0, 4'd5},                  // R5 unimpl write
    '{1'b0, 12'h540, 64'h0, 1'b1, 1'b0, 64'h0, 4'd5},                                    // R5 unimpl read
    '{1'b0, 12'h7F0, 64'h0, 1'b1, 1'b0, 64'h0, 4'd5},                                    // R5 last slot
    '{1'b1, 12'h4F0, 64'h1122_3344_5566_7788, 1'b1, 1'b0, 64'h0, 4'd2},
    '{1'b0, 12'h4F0, 64'h0, 1'b1, 1'b0, 64'h1122_3344_5566_7788, 4'd2},                  // R2 top built slot
    '{1'b0, 12'h410, 64'h0, 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, 4'd2}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic open_all();
    dbl_lock = 1'b0; core_on = 1'b1; os_lock = 1'b0; ext_ok = 1'b1; sw_lock = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    open_all();
    for (int s = 0; s < NB; s++) btype[s*4 +: 4] = 4'b0010;
    btype[0*4 +: 4] = 4'b0000;
    btype[2*4 +: 4] = 4'b1000;
    btype[3*4 +: 4] = 4'b0100;

    repeat (3) @(negedge clk);
    chk("R11 vld in reset", {63'd0, rsp_vld}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 vld after reset", {63'd0, rsp_vld}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].w, VEC[i].a, VEC[i].d);
      chk($sformatf("R2 vec%0d vld", i), {63'd0, rsp_vld}, 64'd1);
      chk($sformatf("R%0d vec%0d claim", VEC[i].rq, i), {63'd0, rsp_claim}, {63'd0, VEC[i].claim});
      chk($sformatf("R%0d vec%0d err", VEC[i].rq, i), {63'd0, rsp_err}, {63'd0, VEC[i].err});
      chk($sformatf("R%0d vec%0d data", VEC[i].rq, i), rsp_rdata, VEC[i].rd);
    end
    @(negedge clk);
    chk("R2 vld drops when idle", {63'd0, rsp_vld}, 64'd0);

    // R10 outputs to the match unit
    chk("R10 slot0 view", bval[0*64 +: 64], 64'hFFFF_4567_89AB_CDEC);
    chk("R10 slot1 view", bval[1*64 +: 64], 64'h0123_4567_89AB_CDEF);
    chk("R10 slot3 view", bval[3*64 +: 64], 64'h0);
    btype[0*4 +: 4] = 4'b0010;
    #1;
    chk("R10 R9 slot0 after type flip", bval[0*64 +: 64], 64'h0123_4567_89AB_CDEF);
    btype[0*4 +: 4] = 4'b0000;

    // R4 software lock
    sw_lock = 1'b1;
    acc(1'b1, 12'h410, 64'hAAAA_AAAA_AAAA_AAAA);
    chk("R4 locked write err", {63'd0, rsp_err}, 64'd0);
    acc(1'b0, 12'h410, 64'h0);
    chk("R4 locked read err", {63'd0, rsp_err}, 64'd0);
    chk("R4 locked read data", rsp_rdata, 64'h0123_4567_89AB_CDEF);
    open_all();

    // R3 each blocking condition alone
    for (int c = 0; c < 4; c++) begin
      open_all();
      case (c)
        0: dbl_lock = 1'b1;
        1: core_on  = 1'b0;
        2: os_lock  = 1'b1;
        default: ext_ok = 1'b0;
      endcase
      acc(1'b0, 12'h410, 64'h0);
      chk($sformatf("R3 cond%0d err", c), {63'd0, rsp_err}, 64'd1);
      chk($sformatf("R3 cond%0d data", c), rsp_rdata, 64'd0);
    end
    open_all();
    os_lock = 1'b1;
    acc(1'b1, 12'h410, 64'h5555_5555_5555_5555);
    chk("R3 blocked write err", {63'd0, rsp_err}, 64'd1);
    // R6 unimplemented slot while blocked
    acc(1'b0, 12'h540, 64'h0);
    chk("R6 unimpl blocked err", {63'd0, rsp_err}, 64'd1);
    chk("R6 unimpl blocked data", rsp_rdata, 64'd0);
    acc(1'b0, 12'h3F0, 64'h0);
    chk("R1 unclaimed while blocked err", {63'd0, rsp_err}, 64'd0);
    open_all();
    acc(1'b0, 12'h410, 64'h0);
    chk("R3 blocked write kept value", rsp_rdata, 64'h0123_4567_89AB_CDEF);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule